// File: doc/BRIEF.md
# Double-Buffered Audio Subframe Data Path

This block sits between a host that produces stereo audio samples and a serializer that sends them as two subframes per frame, channel A first, then channel B. The host pushes audio words one at a time into a single holding register. The first word after reset is channel A and the channels then alternate. Each word passes from the holding register into a buffer for its own channel. From there it moves into the subframe load register, whose contents the serializer reads in parallel. Three non-audio bits per channel come from a separate frame register that the host writes. Both channels' non-audio bits are taken from that register at the start of each frame. The channel B bits wait in a non-audio buffer until the second subframe begins.

The serializer pulses `ser_take` when it has sent the last bit of the current subframe, including its parity. On that pulse the block loads the next subframe. After channel B it loads channel A and the non-audio bits for the new frame. After channel A it loads channel B. An empty flag tells the host that there is room for the next frame, and when the interrupt enable is set it also raises an interrupt request. If a buffer has nothing for its subframe, the block resends the audio word it already holds and records the underrun in a sticky status bit.

Host write port rules: a word transfers on any clock edge where `wr_valid` and `wr_ready` are both 1. `wr_ready` is 0 while the holding register is occupied. This includes the case where a channel B word waits for buffer B to drain. The host must hold `wr_valid` and `wr_data` steady until the transfer. The serializer side has no back-pressure: `ser_take` is a single-cycle strobe, and the load register always presents a word.

Top module: `afp_frame_path`

## Requirements
- R1: After reset: `wr_ready`=1, `empty`=1, `irq`=0, `urun`=0, `sh_audio`=0, `sh_nonaudio`=0, `sh_chan_b`=1 (so the first `ser_take` starts a frame), and `wr_next_b`=0.
- R2: A word is accepted on an edge with `wr_valid`=1 and `wr_ready`=1. `wr_ready` is then 0 while the holding register is occupied. Accepted words are assigned to channel A, B, A, B and so on, starting with A after reset. `wr_next_b` is 1 when the next accepted word will be channel B.
- R3: A channel A word in the holding register moves into buffer A on the next edge if buffer A is empty. Otherwise it stays in the holding register until buffer A empties.
- R4: A channel B word stays in the holding register, with `wr_ready`=0, until buffer B is empty. It moves on the edge after buffer B empties.
- R5: `ser_take` while `sh_chan_b`=1 starts a frame. On the next edge `sh_audio` gets buffer A, buffer A empties, `sh_nonaudio` gets `na_data` bits [2:0] as last written, those bits [5:3] are copied into the non-audio buffer, and `sh_chan_b` becomes 0.
- R6: `ser_take` while `sh_chan_b`=0 loads channel B. `sh_audio` gets buffer B, buffer B empties, `sh_nonaudio` gets the non-audio buffer, and `sh_chan_b` becomes 1.
- R7: Writing the frame register (`na_we`) affects only the next frame start. A write made after a frame start does not change the channel B bits of that same frame.
- R8: `empty` is 1 exactly when the holding register and buffer A are both empty. It goes to 0 on the edge that accepts a host word. A frame-register write does not change it.
- R9: `irq` is 1 only when `empty`=1 and `irq_en`=1.
- R10: If `ser_take` finds the buffer for the next subframe empty, `sh_audio` keeps its value. The channel still switches and the non-audio bits still load as in R5 or R6, and `urun` is set. `urun` stays 1 until `urun_clr`. If a new underrun and `urun_clr` occur on the same edge, `urun` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host offers an audio word |
| wr_ready | output | 1 | Holding register can accept a word |
| wr_data | input | 24 | Audio word from host |
| wr_next_b | output | 1 | Next accepted word belongs to channel B |
| na_we | input | 1 | Write strobe for the frame non-audio register |
| na_data | input | 6 | Non-audio bits: [2:0] channel A, [5:3] channel B |
| ser_take | input | 1 | Serializer finished a subframe; load the next one |
| sh_audio | output | 24 | Audio word of the current subframe |
| sh_nonaudio | output | 3 | Non-audio bits of the current subframe |
| sh_chan_b | output | 1 | Current subframe is channel B |
| irq_en | input | 1 | Interrupt enable |
| empty | output | 1 | Room for the next frame |
| irq | output | 1 | Interrupt request |
| urun_clr | input | 1 | Clears the underrun status |
| urun | output | 1 | Sticky underrun status |

## Verification
The bench fills both channel buffers and then pushes the next frame's channel B word while buffer B is still occupied. A design that let that word overwrite buffer B would show the wrong sample in the second subframe, and one that released `wr_ready` too early would swap the channel order. It rewrites the frame register between the channel A and channel B loads of one frame. A design that read channel B's non-audio bits late would show the new bits a frame early. It starves the buffers so that both upload points underrun, and it collides an underrun with a status clear. A design that zeroed the audio word, froze the channel, or let the clear win would show up on the ports. Finally, it writes the frame register while `empty` is high and toggles `irq_en`, which catches an empty flag that clears on the wrong write or an interrupt that ignores the enable.

// File: rtl/afp_pkg.sv
package afp_pkg;
  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/afp_hold_stage.sv
module afp_hold_stage
  import afp_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [AW-1:0]      in_data,
  output logic               next_is_b,
  input  logic [NUM_CH-1:0]  buf_full,
  output logic [NUM_CH-1:0]  mv,
  output logic [AW-1:0]      hold_data
);
  logic  hold_full;
  chan_e hold_ch;
  chan_e next_ch;
  logic  acc;

  assign in_ready  = !hold_full;
  assign acc       = in_valid && !hold_full;
  assign next_is_b = (next_ch == CH_B);

  // A word leaves only toward its own channel buffer, and only when that buffer is free.
  assign mv[0] = hold_full && (hold_ch == CH_A) && !buf_full[0];
  assign mv[1] = hold_full && (hold_ch == CH_B) && !buf_full[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_ch   <= CH_A;
      next_ch   <= CH_A;
      hold_data <= '0;
    end else if (acc) begin
      hold_full <= 1'b1;
      hold_data <= in_data;
      hold_ch   <= next_ch;
      next_ch   <= (next_ch == CH_A) ? CH_B : CH_A;
    end else if (|mv) begin
      hold_full <= 1'b0;
    end
  end

  // R2
  accept_occupies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R4
  stalled_word_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !(|mv)) |=> (hold_full && $stable(hold_data) && $stable(hold_ch)));
endmodule

// File: rtl/afp_chan_buf.sv
module afp_chan_buf #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill,
  input  logic [AW-1:0] fill_data,
  input  logic          drain,
  output logic          full,
  output logic [AW-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (fill) begin
      full <= 1'b1;
      data <= fill_data;
    end else if (drain) begin
      full <= 1'b0;
    end
  end

  // R3
  fill_only_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill |-> !full);

  // R3
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> (full && data == $past(fill_data)));
endmodule

// File: rtl/afp_subframe_ld.sv
module afp_subframe_ld
  import afp_pkg::*;
#(
  parameter int AW = 24,
  parameter int NW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [NUM_CH-1:0]  src_full,
  input  logic [AW-1:0]      a_data,
  input  logic [AW-1:0]      b_data,
  input  logic               na_we,
  input  logic [2*NW-1:0]    na_data,
  input  logic               urun_clr,
  output logic [NUM_CH-1:0]  drain,
  output logic [AW-1:0]      sh_audio,
  output logic [NW-1:0]      sh_na,
  output logic               sh_chan_b,
  output logic               urun
);
  chan_e           cur_ch;
  chan_e           nxt_ch;
  logic [2*NW-1:0] na_q;
  logic [NW-1:0]   na_b_buf;
  logic            nxt_full;
  logic            starve;

  assign nxt_ch    = (cur_ch == CH_B) ? CH_A : CH_B;
  assign nxt_full  = (nxt_ch == CH_A) ? src_full[0] : src_full[1];
  assign starve    = take && !nxt_full;
  assign drain[0]  = take && (nxt_ch == CH_A);
  assign drain[1]  = take && (nxt_ch == CH_B);
  assign sh_chan_b = (cur_ch == CH_B);

  // Frame non-audio register, consumed only at frame start.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      na_q <= '0;
    end else if (na_we) begin
      na_q <= na_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_ch   <= CH_B;
      sh_audio <= '0;
      sh_na    <= '0;
      na_b_buf <= '0;
    end else if (take) begin
      cur_ch <= nxt_ch;
      if (nxt_full) begin
        sh_audio <= (nxt_ch == CH_A) ? a_data : b_data;
      end
      if (nxt_ch == CH_A) begin
        sh_na    <= na_q[NW-1:0];
        na_b_buf <= na_q[2*NW-1:NW];
      end else begin
        sh_na <= na_b_buf;
      end
    end
  end

  // Sticky underrun; a new underrun outranks a clear on the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      urun <= 1'b0;
    end else if (starve) begin
      urun <= 1'b1;
    end else if (urun_clr) begin
      urun <= 1'b0;
    end
  end

  // R5
  take_switches_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (sh_chan_b != $past(sh_chan_b)));

  // R10
  starve_holds_audio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !nxt_full) |=> (urun && $stable(sh_audio)));

  // R10
  urun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (urun && !urun_clr) |=> urun);
endmodule

// File: rtl/afp_frame_path.sv
module afp_frame_path
  import afp_pkg::*;
#(
  parameter int AUDIO_W = 24,
  parameter int NA_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [AUDIO_W-1:0]   wr_data,
  output logic                 wr_next_b,
  input  logic                 na_we,
  input  logic [2*NA_W-1:0]    na_data,
  input  logic                 ser_take,
  output logic [AUDIO_W-1:0]   sh_audio,
  output logic [NA_W-1:0]      sh_nonaudio,
  output logic                 sh_chan_b,
  input  logic                 irq_en,
  output logic                 empty,
  output logic                 irq,
  input  logic                 urun_clr,
  output logic                 urun
);
  logic [NUM_CH-1:0]  mv;
  logic [NUM_CH-1:0]  drain;
  logic [NUM_CH-1:0]  buf_full;
  logic [AUDIO_W-1:0] buf_data [NUM_CH];
  logic [AUDIO_W-1:0] hold_data;

  afp_hold_stage #(.AW(AUDIO_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (wr_valid),
    .in_ready  (wr_ready),
    .in_data   (wr_data),
    .next_is_b (wr_next_b),
    .buf_full  (buf_full),
    .mv        (mv),
    .hold_data (hold_data)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_buf
    afp_chan_buf #(.AW(AUDIO_W)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill      (mv[c]),
      .fill_data (hold_data),
      .drain     (drain[c]),
      .full      (buf_full[c]),
      .data      (buf_data[c])
    );
  end

  afp_subframe_ld #(.AW(AUDIO_W), .NW(NA_W)) u_ld (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (ser_take),
    .src_full  (buf_full),
    .a_data    (buf_data[0]),
    .b_data    (buf_data[1]),
    .na_we     (na_we),
    .na_data   (na_data),
    .urun_clr  (urun_clr),
    .drain     (drain),
    .sh_audio  (sh_audio),
    .sh_na     (sh_nonaudio),
    .sh_chan_b (sh_chan_b),
    .urun      (urun)
  );

  // Holding register free (ready) and buffer A free together mean room for a frame.
  assign empty = wr_ready && !buf_full[0];
  assign irq   = empty && irq_en;

  // R8
  write_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !empty);

  // R5
  frame_start_drains_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_take && sh_chan_b && buf_full[0]) |=> (sh_audio == $past(buf_data[0])));
endmodule

// File: tb/tb_afp_frame_path.sv
module tb_afp_frame_path;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [23:0] wr_data = '0;
  logic        wr_next_b;
  logic        na_we = 1'b0;
  logic [5:0]  na_data = '0;
  logic        ser_take = 1'b0;
  logic [23:0] sh_audio;
  logic [2:0]  sh_nonaudio;
  logic        sh_chan_b;
  logic        irq_en = 1'b0;
  logic        empty;
  logic        irq;
  logic        urun_clr = 1'b0;
  logic        urun;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  afp_frame_path dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_next_b(wr_next_b), .na_we(na_we), .na_data(na_data),
    .ser_take(ser_take), .sh_audio(sh_audio), .sh_nonaudio(sh_nonaudio),
    .sh_chan_b(sh_chan_b), .irq_en(irq_en), .empty(empty), .irq(irq),
    .urun_clr(urun_clr), .urun(urun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [23:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    ser_take = 1'b1;
    @(negedge clk);
    ser_take = 1'b0;
  endtask

  task automatic na_wr(input logic [5:0] d);
    @(negedge clk);
    na_we   = 1'b1;
    na_data = d;
    @(negedge clk);
    na_we = 1'b0;
  endtask

  task automatic t_reset();
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 empty", empty, 1);
    chk("R1 irq", irq, 0);
    chk("R1 urun", urun, 0);
    chk("R1 sh_audio", sh_audio, 0);
    chk("R1 sh_nonaudio", sh_nonaudio, 0);
    chk("R1 sh_chan_b", sh_chan_b, 1);
    chk("R1 wr_next_b", wr_next_b, 0);
  endtask

  task automatic t_basic_frame();
    irq_en = 1'b1;
    na_wr(6'b101_011);
    put(24'h111111);
    chk("R2 ready low while held", wr_ready, 0);
    chk("R8 empty cleared by write", empty, 0);
    chk("R2 next is B", wr_next_b, 1);
    idle(1);
    chk("R3 A word moved, ready back", wr_ready, 1);
    put(24'h222222);
    chk("R2 next is A", wr_next_b, 0);
    idle(1);
    chk("R9 no irq when not empty", irq, 0);
    take();
    chk("R5 audio A", sh_audio, 24'h111111);
    chk("R5 nonaudio A", sh_nonaudio, 3'b011);
    chk("R5 chan A", sh_chan_b, 0);
    chk("R8 empty after A drained", empty, 1);
    chk("R9 irq raised", irq, 1);
    take();
    chk("R6 audio B", sh_audio, 24'h222222);
    chk("R6 nonaudio B", sh_nonaudio, 3'b101);
    chk("R6 chan B", sh_chan_b, 1);
    chk("R10 no underrun", urun, 0);
  endtask

  task automatic t_b_backpressure();
    put(24'hA00001);
    put(24'hB00001);
    idle(1);
    take();
    chk("R5 A1 loaded", sh_audio, 24'hA00001);
    put(24'hA00002);
    idle(1);
    put(24'hB00002);
    idle(3);
    chk("R4 B2 waits, ready low", wr_ready, 0);
    chk("R8 not empty with A2 buffered", empty, 0);
    take();
    chk("R6 B1 loaded", sh_audio, 24'hB00001);
    chk("R4 still held on drain edge", wr_ready, 0);
    idle(1);
    chk("R4 B2 moved after drain", wr_ready, 1);
    take();
    chk("R5 A2 loaded", sh_audio, 24'hA00002);
    chk("R5 nonaudio A from frame reg", sh_nonaudio, 3'b011);
    na_wr(6'b010_110);
    take();
    chk("R6 B2 loaded", sh_audio, 24'hB00002);
    chk("R7 B bits from frame start", sh_nonaudio, 3'b101);
  endtask

  task automatic t_underrun();
    chk("R10 clear before starve", urun, 0);
    take();
    chk("R10 audio reused at A", sh_audio, 24'hB00002);
    chk("R7 new A bits at next frame", sh_nonaudio, 3'b110);
    chk("R10 chan still switches", sh_chan_b, 0);
    chk("R10 urun set", urun, 1);
    take();
    chk("R10 audio reused at B", sh_audio, 24'hB00002);
    chk("R7 new B bits", sh_nonaudio, 3'b010);
    chk("R10 urun sticky", urun, 1);
    @(negedge clk);
    urun_clr = 1'b1;
    @(negedge clk);
    urun_clr = 1'b0;
    chk("R10 urun cleared", urun, 0);
    @(negedge clk);
    ser_take = 1'b1;
    urun_clr = 1'b1;
    @(negedge clk);
    ser_take = 1'b0;
    urun_clr = 1'b0;
    chk("R10 set wins over clear", urun, 1);
    @(negedge clk);
    urun_clr = 1'b1;
    @(negedge clk);
    urun_clr = 1'b0;
    put(24'hA00003);
    put(24'hB00003);
    idle(1);
    take();
    chk("R6 recovery B3", sh_audio, 24'hB00003);
    chk("R10 no new underrun", urun, 0);
    take();
    chk("R5 recovery A3", sh_audio, 24'hA00003);
    chk("R5 chan A", sh_chan_b, 0);
  endtask

  task automatic t_empty_irq();
    chk("R8 empty before na write", empty, 1);
    na_wr(6'b111_111);
    chk("R8 na write keeps empty", empty, 1);
    @(negedge clk);
    irq_en = 1'b0;
    @(negedge clk);
    chk("R9 irq masked", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R9 irq unmasked", irq, 1);
    put(24'hA00004);
    chk("R8 write clears empty", empty, 0);
    chk("R9 irq drops", irq, 0);
    idle(2);
    chk("R8 A buffered keeps empty low", empty, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic_frame();
    t_b_backpressure();
    t_underrun();
    t_empty_irq();
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule